// File: doc/BRIEF.md
# LFSR Terminal-Count Timer

This block is an event timer for places where only the end of a count matters, such as a FIFO occupancy limit or a timeout. Instead of a binary counter and a wide equality decoder, it steps a one-to-many (Galois) linear feedback shift register. The feedback bit is the top stage combined with a NOR of all lower stages, so the register passes through every one of its 2^N states, including all-zero, and cannot lock up.

A parameterised terminal value is compared against the register, and a registered one-cycle strobe marks the cycle after the register held that value while stepping. The count order is pseudo-random but fixed, so the strobe arrives after a known number of enabled clocks. The user can pause the timer with the enable input and return it to the all-zero start state with a synchronous restart; an asynchronous reset also clears it.

Internally a small command decoder turns the restart and enable inputs into one of three commands: CMD_CLEAR (restart high), CMD_STEP (restart low, enable high) and CMD_HOLD (both low). The shift register and the terminal match stage both act on that command.

Top module: `lfsr_tc_timer`

## Requirements
- R1: While `arst_i` is high, `count_o` is zero and `term_o` is low; the clear takes effect without waiting for a clock edge.
- R2: On a CMD_STEP edge the register moves by the rule: fb = top stage XOR (NOR of all lower stages); stage 0 takes fb; stage i (i >= 1) takes stage i-1, XORed with fb when bit i-1 of TAP_MASK is 1. With WIDTH=4 and TAP_MASK=4'b1100 the order from zero is 0,9,B,F,7,E,5,A,D,3,6,C,1,2,4,8, then back to 0.
- R3: Starting from zero with the enable held high, all 2^WIDTH values appear exactly once within 2^WIDTH steps, and the register is back at zero after exactly 2^WIDTH steps.
- R4: With `restart_i` and `enable_i` both low, `count_o` keeps its value and `term_o` is low on the following cycle, even while the register holds the terminal value.
- R5: With `restart_i` high, the next edge loads zero into the register whatever `enable_i` is (restart wins over enable).
- R6: `term_o` is high for exactly the one cycle that follows an edge at which `count_o` equalled TERM_VALUE (default 4'b1000), `enable_i` was high and `restart_i` was low; it is never high two cycles in a row.
- R7: With the enable held high and no restart, `term_o` pulses once every 2^WIDTH cycles; starting from zero the first pulse follows the 2^WIDTH-th edge.
- R8: The all-zero state is not a lock-up state: a CMD_STEP edge from zero leaves zero (to 4'b1001 at the default taps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| arst_i | input | 1 | Asynchronous reset, active high; clears the register and the strobe |
| restart_i | input | 1 | Synchronous restart to the all-zero state; takes priority over enable |
| enable_i | input | 1 | Step enable; the register holds while low |
| count_o | output | WIDTH | Raw shift-register state |
| term_o | output | 1 | Registered one-cycle terminal-count strobe |

## Verification
The stepping rule is tried with the enable held high for one full period from zero, where each value is compared against an independent model of the rule and logged to show that no state repeats before the wrap; a three-period run then shows the strobe spacing apart from the state order. The enable is dropped exactly while the register sits on the terminal value, which separates a strobe that respects the enable from one that looks only at the count, and a later resume shows the strobe is emitted once. Restart is applied with the enable both high and low and while the register holds the terminal value, telling restart priority and strobe suppression apart from a plain hold, and a mid-run asynchronous reset followed by a step from zero shows that zero is a passing state and not a sink.

// File: rtl/lfsr_tc_pkg.sv
package lfsr_tc_pkg;

    // Command applied to the shift register and the match stage each edge.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_CLEAR = 2'd2
    } lfsr_cmd_e;

endpackage

// File: rtl/lfsr_tc_ctrl.sv
module lfsr_tc_ctrl
    import lfsr_tc_pkg::*;
(
    input  logic      restart_i,
    input  logic      enable_i,
    output lfsr_cmd_e cmd_o
);

    // Restart wins over enable; with neither the register is held.
    always_comb begin
        unique casez ({restart_i, enable_i})
            2'b1?:   cmd_o = CMD_CLEAR;
            2'b01:   cmd_o = CMD_STEP;
            default: cmd_o = CMD_HOLD;
        endcase
    end

endmodule

// File: rtl/lfsr_tc_shift.sv
module lfsr_tc_shift
    import lfsr_tc_pkg::*;
#(
    parameter int unsigned       WIDTH    = 4,
    parameter logic [WIDTH-1:0]  TAP_MASK = 4'b1100
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  lfsr_cmd_e        cmd_i,
    output logic [WIDTH-1:0] state_o
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] next_step;
    logic             lower_zero;
    logic             feedback;

    // Extending the feedback with a NOR of the lower stages splices the
    // all-zero state into the maximal sequence.
    assign lower_zero = ~|state_q[TOP-1:0];
    assign feedback   = state_q[TOP] ^ lower_zero;

    assign next_step[0] = feedback;

    for (genvar gi = 1; gi < WIDTH; gi++) begin : g_stage
        if (TAP_MASK[gi-1]) begin : g_tap
            assign next_step[gi] = state_q[gi-1] ^ feedback;
        end else begin : g_plain
            assign next_step[gi] = state_q[gi-1];
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            state_q <= '0;
        end else begin
            unique case (cmd_i)
                CMD_CLEAR: state_q <= '0;
                CMD_STEP:  state_q <= next_step;
                default:   state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/lfsr_tc_match.sv
module lfsr_tc_match
    import lfsr_tc_pkg::*;
#(
    parameter int unsigned      WIDTH      = 4,
    parameter logic [WIDTH-1:0] TERM_VALUE = 4'b1000
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  lfsr_cmd_e        cmd_i,
    input  logic [WIDTH-1:0] state_i,
    output logic             term_o
);

    logic term_q;

    // Only a stepping edge leaves the terminal state, so the strobe is one
    // cycle wide by construction of the command decode.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            term_q <= 1'b0;
        end else begin
            term_q <= (cmd_i == CMD_STEP) && (state_i == TERM_VALUE);
        end
    end

    assign term_o = term_q;

endmodule

// File: rtl/lfsr_tc_timer.sv
module lfsr_tc_timer
    import lfsr_tc_pkg::*;
#(
    parameter int unsigned      WIDTH      = 4,
    parameter logic [WIDTH-1:0] TAP_MASK   = 4'b1100,
    parameter logic [WIDTH-1:0] TERM_VALUE = {1'b1, {(WIDTH-1){1'b0}}}
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             restart_i,
    input  logic             enable_i,
    output logic [WIDTH-1:0] count_o,
    output logic             term_o
);

    lfsr_cmd_e        cmd;
    logic [WIDTH-1:0] state;

    lfsr_tc_ctrl u_ctrl (
        .restart_i (restart_i),
        .enable_i  (enable_i),
        .cmd_o     (cmd)
    );

    lfsr_tc_shift #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) u_shift (
        .clk_i   (clk_i),
        .arst_i  (arst_i),
        .cmd_i   (cmd),
        .state_o (state)
    );

    lfsr_tc_match #(
        .WIDTH      (WIDTH),
        .TERM_VALUE (TERM_VALUE)
    ) u_match (
        .clk_i   (clk_i),
        .arst_i  (arst_i),
        .cmd_i   (cmd),
        .state_i (state),
        .term_o  (term_o)
    );

    assign count_o = state;

endmodule

// File: rtl/lfsr_tc_timer_chk.sv
module lfsr_tc_timer_chk #(
    parameter int unsigned      WIDTH      = 4,
    parameter logic [WIDTH-1:0] TERM_VALUE = 4'b1000
) (
    input logic             clk_i,
    input logic             arst_i,
    input logic             restart_i,
    input logic             enable_i,
    input logic [WIDTH-1:0] count_o,
    input logic             term_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        arst_i |-> (count_o == '0) && !term_o);  // R1

    AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (arst_i)
        (!restart_i && !enable_i) |=> $stable(count_o) && !term_o);  // R4

    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (arst_i)
        restart_i |=> (count_o == '0));  // R5

    AST_TERM_FIRES: assert property (@(posedge clk_i) disable iff (arst_i)
        (enable_i && !restart_i && count_o == TERM_VALUE) |=> term_o);  // R6

    AST_TERM_CAUSED: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(term_o) |-> $past(enable_i && !restart_i && count_o == TERM_VALUE));  // R6

    AST_TERM_SINGLE: assert property (@(posedge clk_i) disable iff (arst_i)
        term_o |=> !term_o);  // R6

    AST_ZERO_LEAVES: assert property (@(posedge clk_i) disable iff (arst_i)
        (count_o == '0 && enable_i && !restart_i) |=> (count_o != '0));  // R8

endmodule

bind lfsr_tc_timer lfsr_tc_timer_chk #(
    .WIDTH      (WIDTH),
    .TERM_VALUE (TERM_VALUE)
) u_chk (
    .clk_i     (clk_i),
    .arst_i    (arst_i),
    .restart_i (restart_i),
    .enable_i  (enable_i),
    .count_o   (count_o),
    .term_o    (term_o)
);

// File: tb/lfsr_tc_timer_tb_top.sv
module lfsr_tc_timer_tb_top;

    localparam int unsigned W      = 4;
    localparam int unsigned PERIOD = 1 << W;
    localparam logic [W-1:0] TAPS  = 4'b1100;
    localparam logic [W-1:0] TERM  = 4'b1000;

    logic         clk = 1'b0;
    logic         arst;
    logic         restart;
    logic         enable;
    logic [W-1:0] count;
    logic         term;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    lfsr_tc_timer #(
        .WIDTH      (W),
        .TAP_MASK   (TAPS),
        .TERM_VALUE (TERM)
    ) dut_i (
        .clk_i     (clk),
        .arst_i    (arst),
        .restart_i (restart),
        .enable_i  (enable),
        .count_o   (count),
        .term_o    (term)
    );

    // Stepping rule as written in R2.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] s);
        logic [W-1:0] n;
        logic fb;
        fb   = s[W-1] ^ (s[W-2:0] == '0);
        n[0] = fb;
        for (int i = 1; i < W; i++) n[i] = TAPS[i-1] ? (s[i-1] ^ fb) : s[i-1];
        return n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        arst = 1'b1; restart = 1'b0; enable = 1'b1;
        #1;
        chk("R1 count in reset", count, 0);
        chk("R1 term in reset", term, 0);
        tick(); tick();
        chk("R1 count held in reset", count, 0);
        arst = 1'b0; enable = 1'b0;
        tick();
        chk("R1 count after release", count, 0);
    endtask

    task automatic t_full_period();
        logic [W-1:0] exp_s;
        logic [W-1:0] prev;
        bit seen [PERIOD];
        for (int i = 0; i < PERIOD; i++) seen[i] = 0;
        exp_s = '0;
        enable = 1'b1;
        for (int k = 1; k <= PERIOD; k++) begin
            prev  = exp_s;
            exp_s = model_next(exp_s);
            tick();
            chk("R2 step value", count, exp_s);
            chk("R3 no early repeat", seen[count], 0);
            seen[count] = 1;
            chk("R6 term follows terminal", term, prev == TERM);
        end
        chk("R3 wraps to zero after 2^N", count, 0);
        enable = 1'b0;
    endtask

    task automatic t_term_interval();
        int last = 0;
        int pulses = 0;
        enable = 1'b1;
        for (int k = 1; k <= 3 * PERIOD; k++) begin
            tick();
            if (term) begin
                pulses++;
                chk("R7 pulse spacing", k - last, PERIOD);
                last = k;
            end
        end
        chk("R7 pulse count over 3 periods", pulses, 3);
        enable = 1'b0;
    endtask

    task automatic t_hold();
        enable = 1'b1;
        for (int k = 0; k < PERIOD - 1; k++) tick();
        chk("R2 reaches terminal", count, TERM);
        enable = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R4 count held", count, TERM);
            chk("R4 no term while held", term, 0);
        end
        enable = 1'b1;
        tick();
        chk("R6 term on resume", term, 1);
        chk("R3 wrap after resume", count, 0);
        tick();
        chk("R6 term single cycle", term, 0);
        chk("R8 leaves zero", count, 4'h9);
        enable = 1'b0;
    endtask

    task automatic t_restart();
        enable = 1'b1;
        tick(); tick(); tick();
        chk("R2 advance before restart", count, 4'h7);
        restart = 1'b1;
        tick();
        chk("R5 restart with enable", count, 0);
        chk("R5 no term on restart", term, 0);
        enable = 1'b0;
        tick();
        chk("R5 restart without enable", count, 0);
        restart = 1'b0; enable = 1'b1;
        for (int k = 0; k < PERIOD - 1; k++) tick();
        chk("R5 terminal again", count, TERM);
        restart = 1'b1;
        tick();
        chk("R6 restart suppresses term", term, 0);
        chk("R5 restart from terminal", count, 0);
        restart = 1'b0; enable = 1'b0;
    endtask

    task automatic t_lockup();
        enable = 1'b1;
        tick(); tick();
        arst = 1'b1;
        #1;
        chk("R1 async clear mid-run", count, 0);
        tick();
        arst = 1'b0; enable = 1'b0;
        tick(); tick();
        chk("R8 zero held while idle", count, 0);
        enable = 1'b1;
        tick();
        chk("R8 step from zero", count, 4'h9);
        tick();
        chk("R8 continues", count, 4'hB);
        enable = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        arst = 1'b1; restart = 1'b0; enable = 1'b0;
        t_reset();
        t_full_period();
        t_term_interval();
        t_hold();
        t_restart();
        t_lockup();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule